// File: doc/BRIEF.md
# Banked Feature-Map Buffer Controller

This block is the on-chip store for binary activation maps passed between layers of a small convolutional network. Storage is split into eight banks, one per channel. Each bank holds 72 rows of 72 single-bit activations, so the whole buffer is 40.5 Kbit. That is enough for the widest map the network produces. A bank row is always moved whole: one access reads or writes a full 72-bit line of one channel.

Before a layer runs, the layer logic loads the number of channels it uses. Banks below that count are switched on and the remaining banks are gated off, so they see no enable activity. A newly enabled bank becomes usable only after a fixed wake-up time. Requests that arrive during that time are stalled. Requests to a gated bank, or to a row that does not exist, are refused with an error, and no storage changes. Gating a bank discards its contents. A later read of a row that has not been rewritten returns all zeros and raises an invalid flag.

Top module: `fmap_bank_buf`

## Requirements
- R1: After reset, all banks are disabled and not ready, `rd_valid` is low, and every activity counter reads zero.
- R2: When `cfg_valid` is high with `cfg_chans` = N and 1 ≤ N ≤ 8, banks 0 to N-1 are enabled and the rest are disabled from the next clock edge onward. A `cfg_chans` value of 0 or above 8 changes nothing.
- R3: A bank raises `bank_ready` exactly 4 clock edges after it becomes enabled. A disabled bank is never ready.
- R4: A request to an enabled bank that is not yet ready raises `req_stall` in the same cycle. It stores nothing, produces no read response and changes no counter.
- R5: A request to a disabled bank, or to a row of 72 or above, raises `req_err` in the same cycle. It stores nothing, produces no read response and changes no counter.
- R6: An accepted write (`req_we`=1) stores the full 72-bit `req_wdata` at row `req_row` of bank `req_chan`. An accepted read (`req_we`=0) drives `rd_valid` high on the next cycle, with that row on `rd_data`.
- R7: An accepted read of a row that has not been written since its bank was last enabled returns `rd_data` = 0 with `rd_invalid` = 1. A read of a written row returns `rd_invalid` = 0.
- R8: Disabling a bank for at least one cycle discards every row it held.
- R9: Bank i has a 16-bit activity counter at `act_count[16*i +: 16]`. It increases by one for each accepted access to that bank and stays unchanged while the bank is disabled.
- R10: Banks are independent: the same row index in different channels holds different data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Load a new channel count |
| cfg_chans | input | 4 | Channel count of the coming layer (1..8) |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = write row, 0 = read row |
| req_chan | input | 3 | Channel, which selects the bank |
| req_row | input | 7 | Row index (0..71) |
| req_wdata | input | 72 | Row data to write |
| req_stall | output | 1 | Target bank is waking up; request not taken |
| req_err | output | 1 | Target bank gated or row out of range; request refused |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data | output | 72 | Read row |
| rd_invalid | output | 1 | Read row was not written since its bank was enabled |
| bank_en | output | 8 | Per-bank enable |
| bank_ready | output | 8 | Per-bank wake-up complete |
| act_count | output | 128 | Per-bank accepted-access counters, 16 bits each |

## Verification
Requests are sent to a bank while it wakes up, while it is gated, and after it is ready. This separates the stall path from the error path, and both of them from a true access. Writes to the same row index in several channels, followed by reads, show whether the channel really selects the bank. A reconfiguration that shrinks and then regrows the active set shows whether gated contents are discarded and whether out-of-range counts are ignored. Every cycle, each output and each counter is compared against a behavioural model of enables, wake timers, row data and validity.

// File: rtl/fmap_bank_buf.sv
module fmap_bank_buf #(
  parameter int NB   = 8,
  parameter int ROWS = 72,
  parameter int W    = 72,
  parameter int WAKE = 4,
  parameter int CW   = 16,
  localparam int CHW = $clog2(NB),
  localparam int RW  = $clog2(ROWS),
  localparam int NW  = $clog2(NB + 1),
  localparam int WKW = $clog2(WAKE + 1),
  localparam int AW  = $clog2(NB * ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic [NW-1:0]    cfg_chans,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [CHW-1:0]   req_chan,
  input  logic [RW-1:0]    req_row,
  input  logic [W-1:0]     req_wdata,
  output logic             req_stall,
  output logic             req_err,
  output logic             rd_valid,
  output logic [W-1:0]     rd_data,
  output logic             rd_invalid,
  output logic [NB-1:0]    bank_en,
  output logic [NB-1:0]    bank_ready,
  output logic [NB*CW-1:0] act_count
);
  logic [NW-1:0]   act_n;
  logic [WKW-1:0]  wake [NB];
  logic [ROWS-1:0] vld  [NB];
  logic [CW-1:0]   cnt  [NB];
  logic [W-1:0]    mem  [NB*ROWS];
  logic [NB-1:0]   hit;
  logic            chan_ok, row_ok, tgt_en, tgt_rdy, acc;
  logic [AW-1:0]   addr;

  assign chan_ok   = int'(req_chan) < NB;
  assign row_ok    = int'(req_row) < ROWS;
  assign tgt_en    = chan_ok && bank_en[req_chan];
  assign tgt_rdy   = chan_ok && bank_ready[req_chan];
  assign req_err   = req_valid && (!tgt_en || !row_ok);
  assign req_stall = req_valid && !req_err && !tgt_rdy;
  assign acc       = req_valid && !req_err && tgt_rdy;
  assign addr      = AW'(int'(req_chan) * ROWS + int'(req_row));

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign bank_en[g]             = NW'(g) < act_n;
    assign bank_ready[g]          = bank_en[g] && (wake[g] == WKW'(WAKE));
    assign hit[g]                 = acc && (req_chan == CHW'(g));
    assign act_count[g*CW +: CW] = cnt[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wake[g] <= '0;
        vld[g]  <= '0;
        cnt[g]  <= '0;
      end else begin
        if (!bank_en[g]) begin
          wake[g] <= '0;
          vld[g]  <= '0;
        end else begin
          if (wake[g] != WKW'(WAKE)) wake[g] <= wake[g] + 1'b1;
          if (hit[g] && req_we) vld[g][req_row] <= 1'b1;
        end
        if (hit[g]) cnt[g] <= cnt[g] + 1'b1;
      end
    end

    p_wake_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_en[g]) |=> !bank_ready[g]);
    p_gated_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_en[g] |=> $stable(act_count[g*CW +: CW]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_n <= '0;
    else if (cfg_valid && cfg_chans != '0 && cfg_chans <= NW'(NB)) act_n <= cfg_chans;
  end

  always_ff @(posedge clk) begin
    if (acc && req_we) mem[addr] <= req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_invalid <= 1'b0;
      rd_data    <= '0;
    end else begin
      rd_valid   <= acc && !req_we;
      rd_invalid <= acc && !req_we && !vld[req_chan][req_row];
      if (acc && !req_we) rd_data <= vld[req_chan][req_row] ? mem[addr] : '0;
    end
  end

  p_err_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> !rd_valid && $stable(act_count));
  p_stall_inert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_stall |=> !rd_valid && $stable(act_count));
  p_rd_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && !req_err && !req_stall) |=> rd_valid);
endmodule

// File: tb/tb_fmap_bank_buf.sv
module tb_fmap_bank_buf;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 0, req_valid = 0, req_we = 0;
  logic [3:0] cfg_chans = 0;
  logic [2:0] req_chan = 0;
  logic [6:0] req_row = 0;
  logic [71:0] req_wdata = 0;
  logic req_stall, req_err, rd_valid, rd_invalid;
  logic [71:0] rd_data;
  logic [7:0] bank_en, bank_ready;
  logic [127:0] act_count;

  fmap_bank_buf dut (.clk, .rst_n, .cfg_valid, .cfg_chans, .req_valid, .req_we,
    .req_chan, .req_row, .req_wdata, .req_stall, .req_err, .rd_valid, .rd_data,
    .rd_invalid, .bank_en, .bank_ready, .act_count);

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  int mact = 0;
  int mwake [8];
  int mcnt [8];
  logic [71:0] mmem [8][72];
  bit mvld [8][72];
  bit erv = 0, einv = 0;
  logic [71:0] erd = 0;

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [71:0] pat(int c, int r);
    return {8'(c), 8'(r), 56'hC3A55A3C0FF0F0};
  endfunction

  task automatic step(bit cv, int cc, bit v, bit we, int ch, int row, logic [71:0] d);
    logic [7:0] een, erdy;
    logic [127:0] ecnt;
    bit eerr, estall, acc;
    cfg_valid = cv; cfg_chans = 4'(cc); req_valid = v; req_we = we;
    req_chan = 3'(ch); req_row = 7'(row); req_wdata = d;
    #1;
    for (int i = 0; i < 8; i++) begin
      een[i]  = i < mact;
      erdy[i] = (i < mact) && (mwake[i] == 4);
      ecnt[i*16 +: 16] = 16'(mcnt[i]);
    end
    eerr   = v && (ch >= mact || row >= 72);
    estall = v && !eerr && !erdy[ch];
    acc    = v && !eerr && !estall;
    chk(bank_en == een, "R2", "bank_en", 128'(bank_en), 128'(een));
    chk(bank_ready == erdy, "R3", "bank_ready", 128'(bank_ready), 128'(erdy));
    chk(req_err == eerr, "R5", "req_err", 128'(req_err), 128'(eerr));
    chk(req_stall == estall, "R4", "req_stall", 128'(req_stall), 128'(estall));
    chk(act_count == ecnt, "R9", "act_count", act_count, ecnt);
    chk(rd_valid == erv, "R6", "rd_valid", 128'(rd_valid), 128'(erv));
    if (erv) begin
      chk(rd_data == erd, "R6", "rd_data", 128'(rd_data), 128'(erd));
      chk(rd_invalid == einv, "R7", "rd_invalid", 128'(rd_invalid), 128'(einv));
    end
    erv = acc && !we;
    if (erv) begin
      einv = !mvld[ch][row];
      erd  = mvld[ch][row] ? mmem[ch][row] : 72'h0;
    end
    if (acc && we) begin mmem[ch][row] = d; mvld[ch][row] = 1; end
    if (acc) mcnt[ch]++;
    for (int i = 0; i < 8; i++) begin
      if (i >= mact) begin
        mwake[i] = 0;
        for (int r = 0; r < 72; r++) mvld[i][r] = 0;
      end else if (mwake[i] < 4) mwake[i]++;
    end
    if (cv && cc >= 1 && cc <= 8) mact = cc;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin mwake[i] = 0; mcnt[i] = 0; end
    for (int i = 0; i < 8; i++) for (int r = 0; r < 72; r++) mvld[i][r] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(bank_en == 0 && bank_ready == 0 && !rd_valid && act_count == 0, "R1",
        "reset state", {bank_en, bank_ready, 111'(act_count), rd_valid}, 128'h0);
    idle(2);
    step(1, 3, 0, 0, 0, 0, 0);                 // R2: three channels
    step(0, 0, 1, 1, 0, 5, pat(0, 5));         // R4: stalled during wake-up
    step(0, 0, 1, 0, 5, 0, 0);                 // R5: gated bank
    step(0, 0, 1, 0, 0, 80, 0);                // R5: row out of range
    idle(2);
    step(0, 0, 1, 1, 0, 5, pat(0, 5));         // R6, R10: same row, three banks
    step(0, 0, 1, 1, 1, 5, pat(1, 5));
    step(0, 0, 1, 1, 2, 71, pat(2, 71));
    step(0, 0, 1, 1, 2, 5, pat(2, 5));
    step(0, 0, 1, 0, 0, 5, 0);
    step(0, 0, 1, 0, 1, 5, 0);
    step(0, 0, 1, 0, 2, 5, 0);
    step(0, 0, 1, 0, 2, 71, 0);
    step(0, 0, 1, 0, 2, 0, 0);                 // R7: never written
    step(1, 9, 0, 0, 0, 0, 0);                 // R2: ignored count
    step(1, 0, 0, 0, 0, 0, 0);                 // R2: ignored count
    step(1, 1, 0, 0, 0, 0, 0);                 // R8: shrink to one bank
    step(0, 0, 1, 0, 1, 5, 0);                 // R5: bank 1 now gated
    step(1, 8, 1, 0, 0, 5, 0);                 // R2: all eight banks
    step(0, 0, 1, 0, 1, 5, 0);                 // R4: bank 1 waking
    idle(4);
    step(0, 0, 1, 0, 1, 5, 0);                 // R8: contents lost -> R7 marker
    step(0, 0, 1, 0, 0, 5, 0);                 // R8: bank 0 kept its row
    for (int c = 0; c < 8; c++) step(0, 0, 1, 1, c, c * 9, pat(c, c * 9));
    for (int c = 7; c >= 0; c--) step(0, 0, 1, 0, c, c * 9, 0);
    step(1, 2, 1, 0, 7, 63, 0);
    idle(3);
    step(0, 0, 1, 1, 6, 1, pat(6, 1));         // R9: gated bank stays idle
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule